// File: doc/BRIEF.md
# Timed Pin Write and Read Sequencer

This block runs one already-decoded 52-bit command at a time against a bank of single-bit pin registers. A write command raises one selected output pin and keeps it high for a counted number of clock cycles. The rise may come at once, after a fixed one-second wait, or after a wait equal to the count itself. A read command waits, then samples one selected input pin and returns that bit with a one-cycle valid strobe. A serial front end can then report it.

Commands arrive on a valid/ready handshake. The sequencer holds `cmd_ready` low while a command is in progress, so a command is accepted only when the sequencer is idle. The number of clock cycles that makes up one second is a parameter. Its default matches a 125 MHz clock.

Top module: `pin_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `cmd_ready` is 1, every bit of `pin_out` is 0 and `rd_valid` is 0.
- R2: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays 0 from the acceptance edge until the command finishes. Any command presented while it is 0 is neither accepted nor executed.
- R3: The command layout is opcode in bits [51:48], pin index in [47:43] and cycle count N in [42:0]. Opcode 4'b0000 drives `pin_out[index]` to 1 from the acceptance edge for exactly N cycles, then returns it to 0 and raises `cmd_ready` on that same edge.
- R4: Opcode 4'b0001 waits SECOND_CYCLES cycles after acceptance, then drives the pin to 1 for N cycles.
- R5: Opcode 4'b0010 waits N cycles after acceptance, then drives the pin to 1 for another N cycles.
- R6: Opcode 4'b1000 samples `pin_in[index]` on the edge N cycles after acceptance. It presents the bit on `rd_data` together with a single-cycle `rd_valid` pulse registered on that edge. A change of the input during the wait is seen.
- R7: Opcode 4'b1001 samples `pin_in[index]` SECOND_CYCLES cycles after acceptance, whatever the count field holds.
- R8: A zero count makes a write (4'b0000, or 4'b0010) drive no pin and finish on the acceptance edge. A 4'b1000 read with a zero count returns its result on the acceptance edge.
- R9: Every other opcode is a no-operation. It finishes on the acceptance edge, changes no pin and produces no `rd_valid`.
- R10: At most one bit of `pin_out` is 1 at any time, and only the selected pin ever rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present on `cmd_data` |
| cmd_ready | output | 1 | Sequencer idle and able to accept a command |
| cmd_data | input | 52 | Opcode, pin index and cycle count |
| pin_in | input | 32 | Input pins sampled by read commands |
| pin_out | output | 32 | Output pin registers driven by write commands |
| rd_valid | output | 1 | One-cycle strobe marking a read result |
| rd_data | output | 1 | Sampled input bit, meaningful with `rd_valid` |

## Verification
The bench builds the sequencer with SECOND_CYCLES set to 20, so both one-second opcodes finish within a few dozen cycles. Their exact rise and sample cycles can then be checked against the counter terminal value. The pin count stays at its default of 32, so indices 0 and 31 are both exercised. Counts of 0, 1 and small values reach the zero-count shortcut and the delay-to-hold handover.

// File: rtl/timed_seq_pkg.sv
// Shared field widths and decoded command types for the pin sequencer.
// Assumes the fixed 52-bit layout: opcode, pin index, cycle count.
package timed_seq_pkg;

    localparam int OP_W   = 4;
    localparam int IDX_W  = 5;
    localparam int CNT_W  = 43;
    localparam int CMD_W  = OP_W + IDX_W + CNT_W;
    localparam int OP_LSB  = IDX_W + CNT_W;
    localparam int IDX_LSB = CNT_W;

    // Opcode values the sequencer understands
    localparam logic [OP_W-1:0] OPC_HOLD       = 4'b0000;
    localparam logic [OP_W-1:0] OPC_SEC_HOLD   = 4'b0001;
    localparam logic [OP_W-1:0] OPC_WAIT_HOLD  = 4'b0010;
    localparam logic [OP_W-1:0] OPC_READ_WAIT  = 4'b1000;
    localparam logic [OP_W-1:0] OPC_READ_SEC   = 4'b1001;

    // What a command does once its wait is over
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_WRITE = 2'd1,
        ACT_READ  = 2'd2
    } act_e;

    // Where the wait before the action comes from
    typedef enum logic [1:0] {
        WAIT_ZERO   = 2'd0,
        WAIT_COUNT  = 2'd1,
        WAIT_SECOND = 2'd2
    } wait_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_HOLD  = 2'd2
    } seq_state_e;

    typedef struct packed {
        act_e              act;
        wait_e             wait_src;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
    } seq_cmd_t;

endpackage

// File: rtl/seq_decode.sv
// Splits a raw command word into action, wait source, pin index and count.
// Purely combinational; unknown opcodes decode to ACT_NONE.
module seq_decode
    import timed_seq_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_word,
    output seq_cmd_t         dec
);

    logic [OP_W-1:0] opc;
    assign opc = cmd_word[OP_LSB +: OP_W];

    // Map each opcode to its action and wait source
    always_comb begin
        dec.idx      = cmd_word[IDX_LSB +: IDX_W];
        dec.cnt      = cmd_word[CNT_W-1:0];
        dec.act      = ACT_NONE;
        dec.wait_src = WAIT_ZERO;
        case (opc)
            OPC_HOLD:      begin dec.act = ACT_WRITE; dec.wait_src = WAIT_ZERO;   end
            OPC_SEC_HOLD:  begin dec.act = ACT_WRITE; dec.wait_src = WAIT_SECOND; end
            OPC_WAIT_HOLD: begin dec.act = ACT_WRITE; dec.wait_src = WAIT_COUNT;  end
            OPC_READ_WAIT: begin dec.act = ACT_READ;  dec.wait_src = WAIT_COUNT;  end
            OPC_READ_SEC:  begin dec.act = ACT_READ;  dec.wait_src = WAIT_SECOND; end
            default:       begin dec.act = ACT_NONE;  dec.wait_src = WAIT_ZERO;   end
        endcase
    end

endmodule

// File: rtl/cycle_timer.sv
// Loadable down-counter. 'expire' is high in the last cycle of a loaded span.
// Assumes a load value of at least 1; the counter rests at zero otherwise.
module cycle_timer #(
    parameter int W = 43
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);

    logic [W-1:0] remain;

    // Load a new span or count the current one down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    // Flag the final cycle of the span
    assign expire = (remain == W'(1));

    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (remain != '0 && !load) |=> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/pin_bank.sv
// Bank of single-bit output registers with per-pin set/clear, plus an
// input-pin selector. Assumes set and clear never target a pin together.
module pin_bank #(
    parameter int NUM_PINS = 32,
    parameter int SEL_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                sample
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        // One output register: raised or dropped only when selected
        always_ff @(posedge clk) begin
            if (!rst_n)
                pin_out[g] <= 1'b0;
            else if (set_en && sel == SEL_W'(g))
                pin_out[g] <= 1'b1;
            else if (clr_en && sel == SEL_W'(g))
                pin_out[g] <= 1'b0;
        end
    end

    // Present the selected input pin for sampling
    assign sample = pin_in[sel];

    p_one_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pin_out));

endmodule

// File: rtl/pin_sequencer.sv
// Timed pin write/read sequencer. Accepts one command when idle, waits the
// decoded delay, then either holds a pin high for the count or samples an
// input pin and pulses rd_valid. Assumes pin_in is synchronous to clk.
module pin_sequencer
    import timed_seq_pkg::*;
#(
    parameter int                NUM_PINS      = 32,
    parameter logic [CNT_W-1:0]  SECOND_CYCLES = 43'd125_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [CMD_W-1:0]    cmd_data,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                rd_valid,
    output logic                rd_data
);

    localparam int SEL_W = $clog2(NUM_PINS);

    seq_cmd_t         dec;
    seq_state_e       state_q, state_d;
    act_e             act_q;
    logic [SEL_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;

    logic             accept;
    logic [CNT_W-1:0] wait_len;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expire;
    logic             pin_set, pin_clr, fire_read;
    logic [SEL_W-1:0] bank_sel;
    logic             bank_sample;

    seq_decode u_dec (
        .cmd_word (cmd_data),
        .dec      (dec)
    );

    cycle_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    pin_bank #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (pin_set),
        .clr_en  (pin_clr),
        .sel     (bank_sel),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .sample  (bank_sample)
    );

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign bank_sel  = cmd_ready ? dec.idx[SEL_W-1:0] : idx_q;

    // Length of the wait chosen by the incoming command
    always_comb begin
        case (dec.wait_src)
            WAIT_COUNT:  wait_len = dec.cnt;
            WAIT_SECOND: wait_len = SECOND_CYCLES;
            default:     wait_len = '0;
        endcase
    end

    // Sequencing: decide timer loads, pin actions and next state
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        pin_set   = 1'b0;
        pin_clr   = 1'b0;
        fire_read = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept && dec.act != ACT_NONE) begin
                    if (wait_len != '0) begin
                        tmr_load = 1'b1;
                        tmr_val  = wait_len;
                        state_d  = ST_DELAY;
                    end else if (dec.act == ACT_READ) begin
                        fire_read = 1'b1;
                    end else if (dec.cnt != '0) begin
                        pin_set  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = dec.cnt;
                        state_d  = ST_HOLD;
                    end
                end
            end
            ST_DELAY: begin
                if (tmr_expire) begin
                    if (act_q == ACT_READ) begin
                        fire_read = 1'b1;
                        state_d   = ST_IDLE;
                    end else if (cnt_q != '0) begin
                        pin_set  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = cnt_q;
                        state_d  = ST_HOLD;
                    end else begin
                        state_d  = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_expire) begin
                    pin_clr = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured command fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_q   <= ACT_NONE;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                act_q <= dec.act;
                idx_q <= dec.idx[SEL_W-1:0];
                cnt_q <= dec.cnt;
            end
        end
    end

    // Read result register with one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 1'b0;
        end else begin
            rd_valid <= fire_read;
            if (fire_read)
                rd_data <= bank_sample;
        end
    end

    p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.act == ACT_NONE) |=>
            (cmd_ready && !rd_valid && pin_out == $past(pin_out)));

    p_pin_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out != '0) |-> !cmd_ready);

    p_hold_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.act == ACT_WRITE && dec.wait_src == WAIT_ZERO && dec.cnt != '0)
            |=> (!cmd_ready && pin_out != '0));

    p_zero_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.act == ACT_WRITE && dec.wait_src != WAIT_SECOND && dec.cnt == '0)
            |=> (cmd_ready && pin_out == '0));

endmodule

// File: tb/pin_sequencer_test.sv
// Directed bench for pin_sequencer: one task per scenario.
module pin_sequencer_test;

    localparam int  NP  = 32;
    localparam int  SEC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [51:0]   cmd_data = '0;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic          rd_valid;
    logic          rd_data;

    int checks = 0;
    int errors = 0;

    pin_sequencer #(.NUM_PINS(NP), .SECOND_CYCLES(43'(SEC))) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_data  (cmd_data),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [51:0] mk(input logic [3:0] op, input logic [4:0] idx, input logic [42:0] n);
        return {op, idx, n};
    endfunction

    // Issue a command, then observe 'win' negedges after the accept edge.
    // Observation 0 is the negedge right after acceptance.
    task automatic run_cmd(input logic [3:0] op, input logic [4:0] idx, input logic [42:0] n,
                           input int win, input int flip_obs, input bit intrude,
                           input logic [4:0] alt_idx,
                           output int first_hi, output int n_hi, output int first_rv,
                           output int n_rv, output bit rv_bit, output int ready_back,
                           output int stray, output int alt_hi);
        first_hi = -1; n_hi = 0; first_rv = -1; n_rv = 0; rv_bit = 1'b0;
        ready_back = -1; stray = 0; alt_hi = 0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = mk(op, idx, n);
        @(posedge clk);
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (intrude && i < 4) begin
                cmd_valid = 1'b1;
                cmd_data  = mk(4'b0000, alt_idx, 43'd2);
            end else begin
                cmd_valid = 1'b0;
            end
            if (pin_out[idx]) begin
                if (first_hi < 0) first_hi = i;
                n_hi++;
            end
            if (pin_out[alt_idx] && alt_idx != idx) alt_hi++;
            if ((pin_out & ~(NP'(1) << idx)) != '0) stray++;
            if (rd_valid) begin
                if (first_rv < 0) begin first_rv = i; rv_bit = rd_data; end
                n_rv++;
            end
            if (cmd_ready && ready_back < 0) ready_back = i;
            if (i == flip_obs) pin_in[idx] = ~pin_in[idx];
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
        chk(pin_out == '0, "R1 pins", pin_out, 0);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_hold(input logic [4:0] idx, input int n);
        int fh, nh, fr, nr, rb, st, ah; bit rv;
        run_cmd(4'b0000, idx, 43'(n), n + 4, -1, 1'b0, idx, fh, nh, fr, nr, rv, rb, st, ah);
        chk(fh == 0, "R3 rise at accept", fh, 0);
        chk(nh == n, "R3 hold length", nh, n);
        chk(rb == n, "R2 ready after hold", rb, n);
        chk(st == 0, "R10 no other pin", st, 0);
    endtask

    task automatic t_sec_hold();
        int fh, nh, fr, nr, rb, st, ah; bit rv;
        run_cmd(4'b0001, 5'd7, 43'd3, SEC + 8, -1, 1'b0, 5'd7, fh, nh, fr, nr, rv, rb, st, ah);
        chk(fh == SEC, "R4 rise after second", fh, SEC);
        chk(nh == 3, "R4 hold length", nh, 3);
        chk(rb == SEC + 3, "R4 ready back", rb, SEC + 3);
    endtask

    task automatic t_wait_hold();
        int fh, nh, fr, nr, rb, st, ah; bit rv;
        run_cmd(4'b0010, 5'd31, 43'd5, 14, -1, 1'b0, 5'd31, fh, nh, fr, nr, rv, rb, st, ah);
        chk(fh == 5, "R5 rise after count", fh, 5);
        chk(nh == 5, "R5 hold length", nh, 5);
        chk(st == 0, "R10 no other pin", st, 0);
    endtask

    task automatic t_read(input int n, input bit level, input int flip_obs, input bit exp_bit);
        int fh, nh, fr, nr, rb, st, ah; bit rv;
        pin_in = '0;
        pin_in[12] = level;
        run_cmd(4'b1000, 5'd12, 43'(n), n + 4, flip_obs, 1'b0, 5'd12, fh, nh, fr, nr, rv, rb, st, ah);
        chk(fr == n, "R6 read timing", fr, n);
        chk(nr == 1, "R6 single pulse", nr, 1);
        chk(rv == exp_bit, "R6 read value", rv, exp_bit);
        pin_in = '0;
    endtask

    task automatic t_read_sec();
        int fh, nh, fr, nr, rb, st, ah; bit rv;
        pin_in = '0;
        pin_in[0] = 1'b1;
        run_cmd(4'b1001, 5'd0, 43'd2, SEC + 4, -1, 1'b0, 5'd0, fh, nh, fr, nr, rv, rb, st, ah);
        chk(fr == SEC, "R7 read after second", fr, SEC);
        chk(rv == 1'b1, "R7 read value", rv, 1);
        chk(nh == 0, "R7 pin untouched", nh, 0);
        pin_in = '0;
    endtask

    task automatic t_zero();
        int fh, nh, fr, nr, rb, st, ah; bit rv;
        run_cmd(4'b0000, 5'd4, 43'd0, 4, -1, 1'b0, 5'd4, fh, nh, fr, nr, rv, rb, st, ah);
        chk(nh == 0, "R8 zero hold no pin", nh, 0);
        chk(rb == 0, "R8 zero hold ready", rb, 0);
        run_cmd(4'b0010, 5'd4, 43'd0, 4, -1, 1'b0, 5'd4, fh, nh, fr, nr, rv, rb, st, ah);
        chk(nh == 0, "R8 zero wait-hold no pin", nh, 0);
        pin_in[9] = 1'b1;
        run_cmd(4'b1000, 5'd9, 43'd0, 4, -1, 1'b0, 5'd9, fh, nh, fr, nr, rv, rb, st, ah);
        chk(fr == 0, "R8 zero read at accept", fr, 0);
        chk(rv == 1'b1, "R8 zero read value", rv, 1);
        pin_in = '0;
    endtask

    task automatic t_nop(input logic [3:0] op);
        int fh, nh, fr, nr, rb, st, ah; bit rv;
        run_cmd(op, 5'd6, 43'd3, 8, -1, 1'b0, 5'd6, fh, nh, fr, nr, rv, rb, st, ah);
        chk(nh == 0 && st == 0, "R9 nop pins", nh + st, 0);
        chk(nr == 0, "R9 nop no read", nr, 0);
        chk(rb == 0, "R9 nop ready", rb, 0);
    endtask

    task automatic t_busy();
        int fh, nh, fr, nr, rb, st, ah; bit rv;
        run_cmd(4'b0000, 5'd5, 43'd6, 12, -1, 1'b1, 5'd9, fh, nh, fr, nr, rv, rb, st, ah);
        chk(ah == 0, "R2 busy command ignored", ah, 0);
        chk(nh == 6, "R2 running command intact", nh, 6);
        chk(rb == 6, "R2 ready low while busy", rb, 6);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_hold(5'd3, 4);
        t_hold(5'd0, 1);
        t_sec_hold();
        t_wait_hold();
        t_read(6, 1'b1, -1, 1'b1);
        t_read(3, 1'b0, 1, 1'b1);
        t_read_sec();
        t_zero();
        t_nop(4'b0101);
        t_nop(4'b1111);
        t_busy();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule